// File: doc/BRIEF.md
# Reference-Compare Interval Timer

This block is a bus-mapped interval timer. A counter, fed either by every bus clock or by one in sixteen, climbs from zero towards a programmed reference value. On the prescaled clock edge where the counter equals the reference, a reference flag is latched. In wrap mode the counter returns to zero on that same edge, which makes the period reference+1 prescaled clocks. To obtain a period of n prescaled clocks, software loads n-1. In free-run mode the counter keeps going and wraps at its full width.

The interrupt output is high while the reference flag is pending and reference interrupts are enabled. Software clears a flag by writing a one to its bit in the event byte. A capture flag is a stub: a one-cycle pulse on `cap_evt` sets it, it is cleared the same way, and it never drives the interrupt. Reads are combinational. Writes land on the clock edge where `bus_sel` and `bus_wr` are high, and byte enables select the lanes.

Top module: `cmp_interval_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: With restart mode set (mode bit 2), the counter goes 0,1,...,REF and then returns to 0, so one period is REF+1 prescaled clocks. This holds for REF=0 too.
- R3: With mode bit 1 set, the counter advances once every 16 bus clocks. The prescaler restarts whenever the timer is disabled, so the first count after enabling comes on the 16th clock edge.
- R4: With restart mode clear, the counter passes REF without returning to 0 and still sets the reference flag.
- R5: While enable (mode bit 0) is 0, the counter reads 0 and does not advance.
- R6: The reference flag (event byte at 0x11, bit 1; 32-bit read at 0x10, bit 9) sets on the prescaled edge where the counter equals REF. `irq` equals the flag ANDed with mode bit 3.
- R7: Writing 1 to an event bit clears that flag. Writing 0 leaves the flag unchanged.
- R8: When a reference hit and a clearing write fall on the same edge, the flag stays set.
- R9: The counter reads at offset 0xC in bits 15:0 at any time, and reading it does not alter counting.
- R10: Mode is at 0x0, the reference is at 0x4 (byte-lane writes), and undefined offsets read 0.
- R11: A pulse on `cap_evt` sets the capture flag (bit 0 of byte 0x11, read bit 8). This flag is cleared by writing 1 and has no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the 32-bit word |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| cap_evt | input | 1 | Capture event pulse (stub) |
| irq | output | 1 | Reference interrupt request |

## Verification
The counting function is tried in two ways. The first uses directed references at the edges: 0 (a period of one clock), a small value under free-run, and a small value with the divide-by-16 path. The second is a seeded random sweep over reference, prescale choice and elapsed clocks. The random sweep separates an inclusive wrap from an exclusive one, and an immediate first prescaled count from one that takes sixteen clocks. A clearing write placed exactly on a hit edge, and another placed one edge later, tell set-priority apart from clear-priority. Zero-valued event writes, writes on a single byte lane and interrupt masking isolate the decode paths.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] A_MODE = 5'h00;
    localparam logic [ADDR_W-1:0] A_REF  = 5'h04;
    localparam logic [ADDR_W-1:0] A_CNT  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_EVT  = 5'h10;
    localparam int MB_EN    = 0;
    localparam int MB_DIV   = 1;
    localparam int MB_WRAP  = 2;
    localparam int MB_IE    = 3;
    localparam int EB_CAP   = 8;
    localparam int EB_REF   = 9;
    localparam int CNT_RD_W = 16;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div_sel,
    output logic tick
);
    localparam logic [DIV_LOG2-1:0] LAST = '1;
    logic [DIV_LOG2-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run || !div_sel) pre_q <= '0;
        else                            pre_q <= pre_q + 1'b1;
    end

    assign tick = run && (!div_sel || pre_q == LAST);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wrap,
    input  logic         tick,
    input  logic [W-1:0] ref_val,
    output logic [W-1:0] cnt,
    output logic         hit
);
    logic at_ref;
    assign at_ref = (cnt == ref_val);
    assign hit    = tick && at_ref;

    always_ff @(posedge clk) begin
        if (!rst_n || !run)       cnt <= '0;
        else if (tick) begin
            if (wrap && at_ref)   cnt <= '0;
            else                  cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_event.sv
module tmr_event (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ref,
    input  logic set_cap,
    input  logic clr_ref,
    input  logic clr_cap,
    output logic ref_flag,
    output logic cap_flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_flag <= 1'b0;
            cap_flag <= 1'b0;
        end else begin
            ref_flag <= set_ref || (ref_flag && !clr_ref);
            cap_flag <= set_cap || (cap_flag && !clr_cap);
        end
    end
endmodule

// File: rtl/cmp_interval_timer.sv
module cmp_interval_timer
    import tmr_pkg::*;
#(
    parameter int REF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_evt,
    output logic              irq
);
    localparam int REF_BYTES = REF_W / 8;

    logic             mode_en, mode_div, mode_wrap, mode_ie;
    logic [REF_W-1:0] ref_q;
    logic [REF_W-1:0] cnt_q;
    logic             tick, hit, ref_flag, cap_flag;
    logic             wr_acc, wr_mode, wr_evt;

    assign wr_acc  = bus_sel && bus_wr;
    assign wr_mode = wr_acc && bus_addr == A_MODE && bus_be[0];
    assign wr_evt  = wr_acc && bus_addr == A_EVT  && bus_be[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_en   <= 1'b0;
            mode_div  <= 1'b0;
            mode_wrap <= 1'b0;
            mode_ie   <= 1'b0;
        end else if (wr_mode) begin
            mode_en   <= bus_wdata[MB_EN];
            mode_div  <= bus_wdata[MB_DIV];
            mode_wrap <= bus_wdata[MB_WRAP];
            mode_ie   <= bus_wdata[MB_IE];
        end
    end

    for (genvar b = 0; b < REF_BYTES; b++) begin : g_ref_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                ref_q[8*b +: 8] <= '0;
            else if (wr_acc && bus_addr == A_REF && bus_be[b])
                ref_q[8*b +: 8] <= bus_wdata[8*b +: 8];
        end
    end

    tmr_prescale #(.DIV_LOG2(4)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(mode_en), .div_sel(mode_div), .tick(tick)
    );

    tmr_count_core #(.W(REF_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(mode_en), .wrap(mode_wrap), .tick(tick),
        .ref_val(ref_q), .cnt(cnt_q), .hit(hit)
    );

    tmr_event u_evt (
        .clk(clk), .rst_n(rst_n),
        .set_ref(hit), .set_cap(cap_evt),
        .clr_ref(wr_evt && bus_wdata[EB_REF]),
        .clr_cap(wr_evt && bus_wdata[EB_CAP]),
        .ref_flag(ref_flag), .cap_flag(cap_flag)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_MODE: begin
                bus_rdata[MB_EN]   = mode_en;
                bus_rdata[MB_DIV]  = mode_div;
                bus_rdata[MB_WRAP] = mode_wrap;
                bus_rdata[MB_IE]   = mode_ie;
            end
            A_REF:  bus_rdata[REF_W-1:0]    = ref_q;
            A_CNT:  bus_rdata[CNT_RD_W-1:0] = cnt_q[CNT_RD_W-1:0];
            A_EVT: begin
                bus_rdata[EB_REF] = ref_flag;
                bus_rdata[EB_CAP] = cap_flag;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq = ref_flag && mode_ie;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int REF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_en,
    input logic             mode_div,
    input logic             mode_wrap,
    input logic             mode_ie,
    input logic             tick,
    input logic [REF_W-1:0] cnt_q,
    input logic [REF_W-1:0] ref_q,
    input logic             ref_flag,
    input logic             irq
);
    // R5: a disabled timer holds zero on the next edge
    a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> cnt_q == '0);

    // R2: inclusive wrap on reaching the reference
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && mode_wrap && tick && cnt_q == ref_q) |=> cnt_q == '0);

    // R4: otherwise a tick steps the counter by one
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && tick && !(mode_wrap && cnt_q == ref_q))
        |=> cnt_q == $past(cnt_q) + 1'b1);

    // R9: no tick, no change
    a_r9_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && !tick) |=> $stable(cnt_q));

    // R8: a hit always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == ref_q) |=> ref_flag);

    // R3: prescaled path never ticks on the first enabled cycle
    a_r3_first_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mode_en) && mode_div) |-> !tick);

    // R6: interrupt masked when disabled in mode
    a_r6_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ie |-> !irq);
endmodule

bind cmp_interval_timer tmr_checker #(.REF_W(REF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .mode_div(mode_div),
    .mode_wrap(mode_wrap), .mode_ie(mode_ie), .tick(tick), .cnt_q(cnt_q),
    .ref_q(ref_q), .ref_flag(ref_flag), .irq(irq)
);

// File: tb/cmp_interval_timer_tb.sv
`timescale 1ns/1ps
module cmp_interval_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, cap_evt = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int n_chk = 0, n_bad = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    cmp_interval_timer #(.REF_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cap_evt(cap_evt), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] b, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = b; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_be = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #0.5 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // mode: bit0 enable, bit1 divide-by-16, bit2 restart, bit3 irq enable
    task automatic arm(input int rv, input bit pre, input bit rs, input bit ie);
        wr(5'h00, 4'b0001, 32'h0);
        wr(5'h10, 4'b0010, 32'h300);
        wr(5'h04, 4'b0011, rv);
        wr(5'h00, 4'b0001, {28'h0, ie, rs, pre, 1'b1});
    endtask

    function automatic int ticks_of(input bit pre, input int n);
        return pre ? n / 16 : n;
    endfunction
    function automatic int exp_cnt(input int rv, input bit pre, input bit rs, input int n);
        int t = ticks_of(pre, n);
        return rs ? t % (rv + 1) : t % 65536;
    endfunction
    function automatic bit exp_flag(input int rv, input bit pre, input int n);
        return ticks_of(pre, n) >= rv + 1;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(5'h00, d); check("R1 mode", d, 0);
        rd(5'h04, d); check("R1 ref", d, 0);
        rd(5'h0C, d); check("R1 cnt", d, 0);
        rd(5'h10, d); check("R1 evt", d, 0);
        check("R1 irq", {31'h0, irq}, 0);

        // R10 map, lane writes, undefined offsets
        wr(5'h04, 4'b0011, 32'hBEEF);
        wr(5'h04, 4'b0001, 32'h0012);
        rd(5'h04, d); check("R10 ref lane0", d, 32'hBE12);
        wr(5'h00, 4'b0001, 32'h6);
        rd(5'h00, d); check("R10 mode rb", d, 32'h6);
        rd(5'h08, d); check("R10 undef 8", d, 0);
        rd(5'h14, d); check("R10 undef 14", d, 0);

        // R5 disabled hold
        wr(5'h04, 4'b0011, 32'h3);
        idle(40);
        rd(5'h0C, d); check("R5 hold zero", d, 0);
        rd(5'h10, d); check("R5 no flag", d, 0);

        // R2 REF=0 period 1
        arm(0, 0, 1, 1);
        idle(5);
        rd(5'h0C, d); check("R2 ref0 cnt", d, 0);
        rd(5'h10, d); check("R6 ref0 flag", d, 32'h200);
        check("R6 irq", {31'h0, irq}, 1);

        // R7 write 0 no effect, then clear
        wr(5'h00, 4'b0001, 32'h0);
        wr(5'h10, 4'b0010, 32'h0);
        rd(5'h10, d); check("R7 zero write", d, 32'h200);
        wr(5'h10, 4'b0010, 32'h200);
        rd(5'h10, d); check("R7 clear", d, 0);

        // R6 irq masked
        arm(2, 0, 1, 0);
        idle(6);
        rd(5'h10, d); check("R6 flag masked", d, 32'h200);
        check("R6 irq masked", {31'h0, irq}, 0);

        // R4 free run past reference
        arm(5, 0, 0, 1);
        idle(10);
        rd(5'h0C, d); check("R4 free cnt", d, 10);
        rd(5'h10, d); check("R4 free flag", d, 32'h200);

        // R9 read does not disturb
        rd(5'h0C, d); rd(5'h0C, d2);
        check("R9 reread", d2, d);
        idle(3);
        rd(5'h0C, d); check("R9 continue", d, 13);

        // R3 first prescaled count at 16
        arm(100, 1, 1, 0);
        idle(15);
        rd(5'h0C, d); check("R3 before16", d, 0);
        idle(1);
        rd(5'h0C, d); check("R3 at16", d, 1);

        // R8 set wins (ref 3: hits at edges 4,8,..)
        arm(3, 0, 1, 1);
        idle(7);
        wr(5'h10, 4'b0010, 32'h200);
        rd(5'h10, d); check("R8 set wins", d, 32'h200);
        arm(3, 0, 1, 1);
        idle(8);
        wr(5'h10, 4'b0010, 32'h200);
        rd(5'h10, d); check("R7 clear off-hit", d, 0);

        // R11 capture stub
        wr(5'h00, 4'b0001, 32'h8);
        wr(5'h10, 4'b0010, 32'h300);
        cap_evt = 1; @(negedge clk); cap_evt = 0;
        rd(5'h10, d); check("R11 cap set", d, 32'h100);
        check("R11 cap no irq", {31'h0, irq}, 0);
        wr(5'h10, 4'b0010, 32'h100);
        rd(5'h10, d); check("R11 cap clear", d, 0);

        // R2 R3 random sweep
        for (int i = 0; i < 24; i++) begin
            int  rv = $urandom_range(0, 40);
            bit  pre = $urandom_range(0, 1);
            int  n = $urandom_range(0, 400);
            arm(rv, pre, 1, 1);
            idle(n);
            rd(5'h0C, d);
            check($sformatf("R2 R3 rand cnt ref=%0d pre=%0d n=%0d", rv, pre, n),
                  d, exp_cnt(rv, pre, 1, n));
            rd(5'h10, d);
            check("R6 rand flag", d, exp_flag(rv, pre, n) ? 32'h200 : 32'h0);
            check("R6 rand irq", {31'h0, irq}, {31'h0, exp_flag(rv, pre, n)});
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule